// File: doc/BRIEF.md
# TS2 Exchange Exit Gate

This block decides when a link-training substate that exchanges TS2 ordered sets may leave for its idle substate. Each lane delivers decoded fields of every received ordered set: a strobe, a flag saying the set was a TS2, a flag saying the link or lane symbol carried PAD, and the link number, lane number, data rate identifier and upconfigure-capability bit. The block compares them with what the local transmitter is sending. It counts per lane how many identical qualifying TS2 sets have arrived in a row. It also counts TS2 sets the local transmitter sends once the first TS2 has been received.

The surrounding state machine pulses `arm` when it enters the substate. It then waits for `exit_pulse`. The rate identifier and upconfigure bit are checked only for agreement among the active lanes. They are never compared with the transmitted values. Once the receive and transmit conditions both hold in the block's state, exit follows even if the partner has since switched to other ordered sets.

Top module: `ts2_exit_gate`

## Requirements
- R1: After reset, `exit_pulse` and `done` are 0 and the block is disarmed. Until the first `arm` pulse, no reception or transmit strobe can produce an exit.
- R2: A reception on lane g qualifies when `rx_ts2[g]`=1, `rx_pad[g]`=0, the link field equals `tx_link` and the lane field equals lane g's slice of `tx_lane`. Exit requires every lane set in `lane_act` to have counted 8 consecutive qualifying sets, and `lane_act` must be non-zero.
- R3: A reception carrying PAD, a mismatched link number or a mismatched lane number does not qualify, and it returns that lane's count to 0.
- R4: Exit requires the stored rate identifier to be identical on all active lanes. Any common value is accepted, because there is no transmitted-rate input.
- R5: Exit requires the stored upconfigure bit to be identical on all active lanes. Either common value is accepted.
- R6: A qualifying set whose rate identifier or upconfigure bit differs from the previous qualifying set on that lane restarts that lane's count at 1. The count saturates at 8.
- R7: A non-TS2 reception (`rx_ts2`=0) on an active lane returns that lane's count to 0.
- R8: `tx_sent` strobes count only in cycles after the cycle in which the first TS2 arrived on an active lane since `arm`. Exit requires 16 of them, and the count saturates at 16.
- R9: `exit_pulse` is high for exactly one cycle. It rises on the clock edge after the edge at which the last condition became true, and `done` rises on the same edge.
- R10: Once the conditions hold in the block's state, exit occurs even if non-TS2 sets arrive in that cycle. While `done`=1, receptions and strobes have no effect and no second pulse occurs.
- R11: `arm` clears `done`, the transmit count and every lane count. An inactive lane's count is held at 0 and does not affect exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Start pulse; clears and arms the block |
| lane_act | input | LANES | Active-lane mask |
| rx_vld | input | LANES | Per-lane received-ordered-set strobe |
| rx_ts2 | input | LANES | Received set is a TS2 |
| rx_pad | input | LANES | Received link or lane symbol was PAD |
| rx_link | input | LANES*LINK_W | Received link numbers, lane 0 in the low bits |
| rx_lane | input | LANES*LANE_W | Received lane numbers |
| rx_rate | input | LANES*RATE_W | Received data rate identifiers |
| rx_upcfg | input | LANES | Received upconfigure-capability bits |
| tx_link | input | LINK_W | Transmitted link number |
| tx_lane | input | LANES*LANE_W | Transmitted lane number per lane |
| tx_sent | input | 1 | Local transmitter sent one TS2 this cycle |
| exit_pulse | output | 1 | One-cycle permission to exit |
| done | output | 1 | Exit has occurred since the last arm |

## Verification
The properties take `arm` to be a single-cycle strobe. They rely on the exit decision being made only while armed, with the transmit count at its limit. The stimulus raises `arm` for one cycle at a time. It changes `lane_act` and the per-lane field values only in cycles with no strobes, so each received set is seen with steady fields. A cycle-level model in the bench tracks counts, stored fields and the pulse timing across PAD, link and lane mismatches, rate and upconfigure disagreement, non-TS2 receptions and transmit-before-receive ordering.

// File: rtl/ts2_exit_gate.sv
module ts2_exit_gate #(
  parameter int LANES   = 4,
  parameter int LINK_W  = 8,
  parameter int LANE_W  = 5,
  parameter int RATE_W  = 5,
  parameter int RX_NEED = 8,
  parameter int TX_NEED = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     arm,
  input  logic [LANES-1:0]         lane_act,
  input  logic [LANES-1:0]         rx_vld,
  input  logic [LANES-1:0]         rx_ts2,
  input  logic [LANES-1:0]         rx_pad,
  input  logic [LANES*LINK_W-1:0]  rx_link,
  input  logic [LANES*LANE_W-1:0]  rx_lane,
  input  logic [LANES*RATE_W-1:0]  rx_rate,
  input  logic [LANES-1:0]         rx_upcfg,
  input  logic [LINK_W-1:0]        tx_link,
  input  logic [LANES*LANE_W-1:0]  tx_lane,
  input  logic                     tx_sent,
  output logic                     exit_pulse,
  output logic                     done
);
  localparam int CW = $clog2(RX_NEED + 1);
  localparam int TW = $clog2(TX_NEED + 1);

  logic                    armed, rx_seen, cond, run;
  logic [TW-1:0]           tx_cnt;
  logic [LANES*CW-1:0]     rx_cnt_flat;
  logic [LANES*RATE_W-1:0] seen_rate;
  logic [LANES-1:0]        seen_up, lane_full;
  logic                    rate_agree, up_agree;

  assign run = armed & ~done & ~cond;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [CW-1:0]     cnt;
    logic [RATE_W-1:0] rate_q;
    logic              up_q, qual, same;

    assign qual = rx_ts2[g] & ~rx_pad[g]
                & (rx_link[g*LINK_W +: LINK_W] == tx_link)
                & (rx_lane[g*LANE_W +: LANE_W] == tx_lane[g*LANE_W +: LANE_W]);
    assign same = (cnt != '0) & (rx_rate[g*RATE_W +: RATE_W] == rate_q)
                & (rx_upcfg[g] == up_q);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt    <= '0;
        rate_q <= '0;
        up_q   <= 1'b0;
      end else if (arm) begin
        cnt <= '0;
      end else if (run) begin
        if (!lane_act[g]) begin
          cnt <= '0;
        end else if (rx_vld[g]) begin
          if (qual) begin
            rate_q <= rx_rate[g*RATE_W +: RATE_W];
            up_q   <= rx_upcfg[g];
            if (!same)                    cnt <= CW'(1);
            else if (cnt != CW'(RX_NEED)) cnt <= cnt + CW'(1);
          end else begin
            cnt <= '0;
          end
        end
      end
    end

    assign lane_full[g]                     = (cnt == CW'(RX_NEED));
    assign rx_cnt_flat[g*CW +: CW]          = cnt;
    assign seen_rate[g*RATE_W +: RATE_W]    = rate_q;
    assign seen_up[g]                       = up_q;
  end

  always_comb begin
    rate_agree = 1'b1;
    up_agree   = 1'b1;
    for (int a = 0; a < LANES; a++) begin
      for (int b = 0; b < LANES; b++) begin
        if (lane_act[a] && lane_act[b]) begin
          if (seen_rate[a*RATE_W +: RATE_W] != seen_rate[b*RATE_W +: RATE_W]) rate_agree = 1'b0;
          if (seen_up[a] != seen_up[b]) up_agree = 1'b0;
        end
      end
    end
  end

  assign cond = armed & ~done & (|lane_act) & (&(lane_full | ~lane_act))
              & rate_agree & up_agree & (tx_cnt == TW'(TX_NEED));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      done       <= 1'b0;
      exit_pulse <= 1'b0;
      rx_seen    <= 1'b0;
      tx_cnt     <= '0;
    end else if (arm) begin
      armed      <= 1'b1;
      done       <= 1'b0;
      exit_pulse <= 1'b0;
      rx_seen    <= 1'b0;
      tx_cnt     <= '0;
    end else begin
      exit_pulse <= cond;
      if (cond) done <= 1'b1;
      if (run) begin
        if (rx_seen && tx_sent && tx_cnt != TW'(TX_NEED)) tx_cnt <= tx_cnt + TW'(1);
        if (|(rx_vld & rx_ts2 & lane_act)) rx_seen <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ts2_exit_gate_chk.sv
module ts2_exit_gate_chk #(
  parameter int LANES   = 4,
  parameter int RX_NEED = 8,
  parameter int TX_NEED = 16,
  parameter int CW      = 4,
  parameter int TW      = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               arm,
  input logic [LANES-1:0]   lane_act,
  input logic               exit_pulse,
  input logic               done,
  input logic               armed,
  input logic [TW-1:0]      tx_cnt,
  input logic [LANES*CW-1:0] rx_cnt_flat
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) exit_pulse |=> !exit_pulse); // R9
  AST_PULSE_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) exit_pulse |-> done); // R9
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (done && !arm) |=> done); // R10
  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) arm |=> (!done && !exit_pulse && tx_cnt == '0)); // R11
  AST_UNARMED_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !armed |-> (!done && !exit_pulse)); // R1
  AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rst_n) tx_cnt <= TW'(TX_NEED)); // R8
  AST_EXIT_TX_MET: assert property (@(posedge clk) disable iff (!rst_n) $rose(exit_pulse) |-> $past(tx_cnt) == TW'(TX_NEED)); // R8
  AST_EXIT_HAS_LANE: assert property (@(posedge clk) disable iff (!rst_n) $rose(exit_pulse) |-> $past(lane_act) != '0); // R2

  for (genvar g = 0; g < LANES; g++) begin : g_bound
    AST_RX_BOUND: assert property (@(posedge clk) disable iff (!rst_n) rx_cnt_flat[g*CW +: CW] <= CW'(RX_NEED)); // R6
  end
endmodule

bind ts2_exit_gate ts2_exit_gate_chk #(
  .LANES(LANES), .RX_NEED(RX_NEED), .TX_NEED(TX_NEED), .CW(CW), .TW(TW)
) chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .lane_act(lane_act), .exit_pulse(exit_pulse),
  .done(done), .armed(armed), .tx_cnt(tx_cnt), .rx_cnt_flat(rx_cnt_flat)
);

// File: tb/ts2_exit_gate_test.sv
module ts2_exit_gate_test;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       b_arm = 1'b0, b_tx = 1'b0;
  logic [3:0] b_act = 4'hF, b_vld = 4'h0, b_ts2 = 4'hF, b_pad = 4'h0, b_up = 4'hF;
  logic [7:0] b_link [4];
  logic [4:0] b_lane [4];
  logic [4:0] b_rate [4];
  logic [7:0] tx_link = 8'h2A;
  logic [19:0] tx_lane = {5'd3, 5'd2, 5'd1, 5'd0};
  logic [31:0] rx_link;
  logic [19:0] rx_lane, rx_rate;
  logic exit_pulse, done;

  always_comb
    for (int l = 0; l < 4; l++) begin
      rx_link[l*8 +: 8] = b_link[l];
      rx_lane[l*5 +: 5] = b_lane[l];
      rx_rate[l*5 +: 5] = b_rate[l];
    end

  ts2_exit_gate uut (
    .clk(clk), .rst_n(rst_n), .arm(b_arm), .lane_act(b_act), .rx_vld(b_vld),
    .rx_ts2(b_ts2), .rx_pad(b_pad), .rx_link(rx_link), .rx_lane(rx_lane),
    .rx_rate(rx_rate), .rx_upcfg(b_up), .tx_link(tx_link), .tx_lane(tx_lane),
    .tx_sent(b_tx), .exit_pulse(exit_pulse), .done(done)
  );

  int checks = 0, fails = 0, pulses = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference
  bit m_armed, m_done, m_pulse, m_seen;
  int m_tx, m_cnt [4], m_rate [4], m_up [4];
  always @(posedge clk) begin
    if (!rst_n) begin
      m_armed = 0; m_done = 0; m_pulse = 0; m_seen = 0; m_tx = 0;
      for (int l = 0; l < 4; l++) begin m_cnt[l] = 0; m_rate[l] = 0; m_up[l] = 0; end
    end else begin
      bit c;
      c = m_armed && !m_done && b_act != 0 && m_tx == 16;
      for (int l = 0; l < 4; l++)
        if (b_act[l]) begin
          if (m_cnt[l] != 8) c = 0;
          for (int k = 0; k < 4; k++)
            if (b_act[k] && (m_rate[l] != m_rate[k] || m_up[l] != m_up[k])) c = 0;
        end
      if (b_arm) begin
        m_armed = 1; m_done = 0; m_pulse = 0; m_seen = 0; m_tx = 0;
        for (int l = 0; l < 4; l++) m_cnt[l] = 0;
      end else if (m_armed && !m_done) begin
        m_pulse = c;
        if (c) m_done = 1;
        else begin
          bit any_ts2;
          any_ts2 = 0;
          for (int l = 0; l < 4; l++) begin
            if (!b_act[l]) m_cnt[l] = 0;
            else if (b_vld[l]) begin
              if (b_ts2[l]) any_ts2 = 1;
              if (b_ts2[l] && !b_pad[l] && b_link[l] == tx_link && b_lane[l] == 5'(l)) begin
                if (m_cnt[l] == 0 || m_rate[l] != int'(b_rate[l]) || m_up[l] != int'(b_up[l])) m_cnt[l] = 1;
                else if (m_cnt[l] < 8) m_cnt[l]++;
                m_rate[l] = b_rate[l];
                m_up[l] = b_up[l];
              end else m_cnt[l] = 0;
            end
          end
          if (m_seen && b_tx && m_tx < 16) m_tx++;
          if (any_ts2) m_seen = 1;
        end
      end else m_pulse = 0;
    end
  end

  always @(negedge clk) if (rst_n && !finished) begin
    if (exit_pulse) pulses++;
    chk(exit_pulse == m_pulse, "R9 pulse vs model", exit_pulse, m_pulse);
    chk(done == m_done, "R10 done vs model", done, m_done);
  end

  task automatic cyc(input logic [3:0] v, input logic t);
    b_vld = v; b_tx = t;
    @(posedge clk); #2;
    b_vld = 4'h0; b_tx = 1'b0;
  endtask
  task automatic burst(input int n, input logic [3:0] v, input logic t);
    repeat (n) cyc(v, t);
  endtask
  task automatic do_arm();
    b_arm = 1'b1; @(posedge clk); #2; b_arm = 1'b0;
  endtask
  task automatic defaults();
    b_act = 4'hF; b_ts2 = 4'hF; b_pad = 4'h0; b_up = 4'hF;
    for (int l = 0; l < 4; l++) begin b_link[l] = 8'h2A; b_lane[l] = 5'(l); b_rate[l] = 5'h06; end
  endtask

  task automatic summary();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
  end

  initial begin
    int p0;
    defaults();
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    chk(exit_pulse == 0 && done == 0, "R1 reset state", done, 0);
    burst(20, 4'hF, 1'b1); burst(2, 4'h0, 1'b0);
    chk(done == 0, "R1 no exit before arm", done, 0);

    // R2/R9/R10: normal exit, partner switches to TS1 in the decisive cycle
    do_arm(); p0 = pulses;
    burst(17, 4'hF, 1'b1);
    b_ts2 = 4'h0; cyc(4'hF, 1'b0); b_ts2 = 4'hF;
    chk(done == 1, "R10 exit despite TS1", done, 1);
    burst(10, 4'hF, 1'b1); burst(2, 4'h0, 1'b0);
    chk(pulses - p0 == 1, "R9 single pulse", pulses - p0, 1);
    chk(done == 1, "R10 done held", done, 1);

    // R3: PAD, link and lane mismatch late in the run
    do_arm(); burst(12, 4'hF, 1'b1);
    b_link[2] = 8'h2B; b_pad[1] = 1'b1; b_lane[3] = 5'd0;
    cyc(4'hF, 1'b1); defaults();
    burst(4, 4'hF, 1'b1); burst(2, 4'h0, 1'b0);
    chk(done == 0, "R3 mismatch resets count", done, 0);
    burst(4, 4'hF, 1'b0); burst(2, 4'h0, 1'b0);
    chk(done == 1, "R2 exit after recount", done, 1);

    // R4: rate disagreement, then agreement on any value
    do_arm(); b_rate[1] = 5'h02;
    burst(17, 4'hF, 1'b1); burst(2, 4'h0, 1'b0);
    chk(done == 0, "R4 rate disagreement blocks", done, 0);
    for (int l = 0; l < 4; l++) b_rate[l] = 5'h1F;
    burst(7, 4'hF, 1'b0); burst(2, 4'h0, 1'b0);
    chk(done == 0, "R6 rate change restarts at one", done, 0);
    burst(1, 4'hF, 1'b0); burst(2, 4'h0, 1'b0);
    chk(done == 1, "R4 common rate accepted", done, 1);
    defaults();

    // R5: upconfigure disagreement
    do_arm(); b_up[3] = 1'b0;
    burst(17, 4'hF, 1'b1); burst(2, 4'h0, 1'b0);
    chk(done == 0, "R5 upcfg disagreement blocks", done, 0);
    b_up[3] = 1'b1;
    burst(8, 4'hF, 1'b0); burst(2, 4'h0, 1'b0);
    chk(done == 1, "R5 agreement allows exit", done, 1);

    // R6: toggling rate on lane 0
    do_arm();
    for (int r = 0; r < 5; r++) begin
      b_rate[0] = (r % 2 == 0) ? 5'h06 : 5'h07;
      burst(4, 4'hF, 1'b1);
    end
    burst(2, 4'h0, 1'b0);
    chk(done == 0, "R6 toggling never fills", done, 0);
    burst(4, 4'hF, 1'b0); burst(2, 4'h0, 1'b0);
    chk(done == 1, "R6 steady fields fill", done, 1);
    defaults();

    // R7: a TS1 clears the lane
    do_arm(); burst(12, 4'hF, 1'b1);
    b_ts2[1] = 1'b0; cyc(4'hF, 1'b1); b_ts2[1] = 1'b1;
    burst(4, 4'hF, 1'b1); burst(2, 4'h0, 1'b0);
    chk(done == 0, "R7 non-TS2 clears count", done, 0);
    burst(4, 4'hF, 1'b0); burst(2, 4'h0, 1'b0);
    chk(done == 1, "R7 exit after recount", done, 1);

    // R8: transmit strobes before the first reception do not count
    do_arm(); burst(20, 4'h0, 1'b1);
    burst(9, 4'hF, 1'b0); burst(2, 4'h0, 1'b0);
    chk(done == 0, "R8 early tx ignored", done, 0);
    burst(15, 4'h0, 1'b1); burst(2, 4'h0, 1'b0);
    chk(done == 0, "R8 fifteen sent not enough", done, 0);
    cyc(4'h0, 1'b1); burst(2, 4'h0, 1'b0);
    chk(done == 1, "R8 sixteenth sent exits", done, 1);

    // R11: re-arm and lane mask
    do_arm();
    chk(done == 0 && exit_pulse == 0, "R11 arm clears done", done, 0);
    b_act = 4'b0011; b_rate[2] = 5'h01; b_ts2[3] = 1'b0;
    burst(17, 4'hF, 1'b1); burst(2, 4'h0, 1'b0);
    chk(done == 1, "R11 inactive lanes ignored", done, 1);
    defaults(); b_act = 4'h0;
    do_arm(); burst(20, 4'hF, 1'b1); burst(2, 4'h0, 1'b0);
    chk(done == 0, "R2 empty mask never exits", done, 0);

    summary();
  end
endmodule